// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block steps through a list of 16-byte transmit descriptors in memory for an Ethernet DMA engine. Each descriptor has four 32-bit words: a status word with an ownership flag, a control word with buffer sizes and flags, and two buffer pointers. The sequencer reads the words one at a time through a request/acknowledge read port. If the DMA owns the descriptor, it presents the buffer pointers, lengths and segment flags to a downstream frame-fetch unit. It then waits for that unit's done handshake and writes a status word back with ownership cleared. Finally it moves to the next descriptor.

The next descriptor can be the list base (end of ring), the pointer held in the second buffer word (chained mode), or the next 16-byte slot. If a descriptor still belongs to software, the sequencer parks in a suspended state until a poll request arrives. Its progress is always visible as a 3-bit process-state code. Three single-cycle event pulses report completion, buffer-unavailable and process-stopped.

Top module: `txd_ring_seq`

## Requirements
- R1: After reset the process state is 000 (stopped). No read, write or job request is active, and all event pulses are low.
- R2: While `run_en` is high in the stopped state, the sequencer loads the list base with its two lowest bits forced to zero. It then reads the descriptor words at offsets 0, 4, 8 and 12 in that order, reporting state 001 while reading.
- R3: If bit 31 of word 0 is 0 (software owned), the sequencer does not read words 1 to 3. It enters state 110 and raises `irq_unavail` for one cycle. It issues no further reads until `poll_req`, which makes it fetch the same descriptor address again.
- R4: A job carries the following fields:
  - buffer 1 pointer from word 2 and buffer 2 pointer from word 3;
  - buffer 1 length from word 1 bits 10:0;
  - buffer 2 length from word 1 bits 21:11, or zero when word 1 bit 24 (chained) is set;
  - first segment from word 1 bit 29 and last segment from bit 30.
- R5: Once an owned descriptor is fully read, `job_valid` is raised in state 010 and held, with its fields stable, until `job_ready`. The state is then 011 until `job_done`.
- R6: On `job_done`, the sequencer enters state 111 and writes word 0 of the descriptor. The written word has bit 31 = 0, bit 15 = the reported error, bits 6:3 = the reported 4-bit collision count, and every other bit zero.
- R7: After the write-back is acknowledged, the next descriptor address is chosen in this priority order:
  - the aligned list base when word 1 bit 25 (end of ring) is set;
  - otherwise word 3 with its two lowest bits cleared when bit 24 (chained) is set;
  - otherwise the current address plus 16.
- R8: `irq_done` pulses for one cycle after a write-back acknowledge, and only when the closed descriptor has both word 1 bit 30 (last segment) and bit 31 (interrupt on completion) set.
- R9: If `run_en` is low when a descriptor closes, or while suspended, the state returns to 000 and `irq_stopped` pulses for one cycle. A later start fetches from the list base again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run/stop control level |
| poll_req | input | 1 | Resume request while suspended |
| ring_base | input | 32 | Descriptor list base address (low two bits ignored) |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Read byte address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Status write-back request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| job_valid | output | 1 | Frame-fetch job offered |
| job_ready | input | 1 | Job accepted by downstream |
| job_buf1_addr | output | 32 | Buffer 1 pointer |
| job_buf1_len | output | 11 | Buffer 1 length |
| job_buf2_addr | output | 32 | Buffer 2 pointer |
| job_buf2_len | output | 11 | Buffer 2 length (zero when chained) |
| job_first | output | 1 | First segment flag |
| job_last | output | 1 | Last segment flag |
| job_done | input | 1 | Downstream payload finished |
| job_err | input | 1 | Error summary for the finished job |
| job_coll | input | 4 | Collision count for the finished job |
| proc_state | output | 3 | Process state code |
| irq_done | output | 1 | Completion pulse |
| irq_unavail | output | 1 | Buffer-unavailable pulse |
| irq_stopped | output | 1 | Process-stopped pulse |

## Verification
The bound checker covers the following on every cycle:
- the state code only takes legal values;
- reads are word aligned;
- an unowned word 0 leads straight to suspension with its pulse;
- an offered job holds steady until accepted;
- a write-back never leaves ownership set;
- the three event pulses last a single cycle and follow the right states.

The bench scenarios show the behaviour that spans several descriptors. This includes the order of next-address choices (sequential, chained, end of ring taking priority over chain), the per-descriptor completion decision, and the status word contents for each reported error and collision count. It also covers refetching after a poll and a stop that waits for the running descriptor to close.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int DW     = 32;
  localparam int LEN_W  = 11;
  localparam int COLL_W = 4;
  localparam int DESC_BYTES = 16;

  typedef enum logic [2:0] {
    ST_STOP  = 3'b000,
    ST_FETCH = 3'b001,
    ST_WAIT  = 3'b010,
    ST_READ  = 3'b011,
    ST_SUSP  = 3'b110,
    ST_CLOSE = 3'b111
  } txd_state_e;

  typedef struct packed {
    logic             ioc;
    logic             last;
    logic             first;
    logic             eor;
    logic             chain;
    logic [LEN_W-1:0] len2;
    logic [LEN_W-1:0] len1;
  } txd_ctrl_t;

  function automatic logic [DW-1:0] word_align(input logic [DW-1:0] a);
    return a & ~DW'(3);
  endfunction

  function automatic logic [DW-1:0] next_desc_addr(
      input logic [DW-1:0] cur, input logic [DW-1:0] base_al,
      input logic eor, input logic chain, input logic [DW-1:0] ptr);
    if (eor)        return base_al;
    else if (chain) return word_align(ptr);
    else            return cur + DW'(DESC_BYTES);
  endfunction

  function automatic logic [DW-1:0] pack_status(
      input logic err, input logic [COLL_W-1:0] coll);
    logic [DW-1:0] w;
    w = '0;
    w[15] = err;
    w[3 +: COLL_W] = coll;
    return w;
  endfunction

  function automatic logic [LEN_W-1:0] eff_len2(input txd_ctrl_t c);
    return c.chain ? '0 : c.len2;
  endfunction
endpackage

// File: rtl/txd_desc_latch.sv
module txd_desc_latch
  import txd_pkg::*;
#(
  parameter int AW = txd_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    idx,
  input  logic [AW-1:0] word,
  output txd_ctrl_t     ctrl,
  output logic [AW-1:0] buf1_ptr,
  output logic [AW-1:0] buf2_ptr
);
  logic [AW-1:0] ptr_q [2:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (load && idx == 2'd1) begin
      ctrl.ioc   <= word[31];
      ctrl.last  <= word[30];
      ctrl.first <= word[29];
      ctrl.eor   <= word[25];
      ctrl.chain <= word[24];
      ctrl.len2  <= word[11 +: LEN_W];
      ctrl.len1  <= word[0 +: LEN_W];
    end
  end

  for (genvar g = 2; g <= 3; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n)                          ptr_q[g] <= '0;
      else if (load && idx == 2'(g))       ptr_q[g] <= word;
    end
  end

  assign buf1_ptr = ptr_q[2];
  assign buf2_ptr = ptr_q[3];
endmodule

// File: rtl/txd_addr_unit.sv
module txd_addr_unit
  import txd_pkg::*;
#(
  parameter int AW = txd_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_base,
  input  logic          advance,
  input  logic [AW-1:0] base,
  input  logic          eor,
  input  logic          chain,
  input  logic [AW-1:0] chain_ptr,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] base_al;
  assign base_al = word_align(base);

  always_ff @(posedge clk) begin
    if (!rst_n)         cur <= '0;
    else if (load_base) cur <= base_al;
    else if (advance)   cur <= next_desc_addr(cur, base_al, eor, chain, chain_ptr);
  end
endmodule

// File: rtl/txd_ring_seq.sv
module txd_ring_seq
  import txd_pkg::*;
#(
  parameter int AW = txd_pkg::DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              poll_req,
  input  logic [AW-1:0]     ring_base,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ack,
  input  logic [AW-1:0]     rd_data,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     wr_data,
  input  logic              wr_ack,
  output logic              job_valid,
  input  logic              job_ready,
  output logic [AW-1:0]     job_buf1_addr,
  output logic [LEN_W-1:0]  job_buf1_len,
  output logic [AW-1:0]     job_buf2_addr,
  output logic [LEN_W-1:0]  job_buf2_len,
  output logic              job_first,
  output logic              job_last,
  input  logic              job_done,
  input  logic              job_err,
  input  logic [COLL_W-1:0] job_coll,
  output logic [2:0]        proc_state,
  output logic              irq_done,
  output logic              irq_unavail,
  output logic              irq_stopped
);
  txd_state_e        st;
  logic [1:0]        widx;
  logic              err_q;
  logic [COLL_W-1:0] coll_q;
  txd_ctrl_t         ctrl;
  logic [AW-1:0]     cur;

  // named internal events
  logic ev_start, ev_word, ev_unowned, ev_close, ev_stop_close, ev_stop_susp;
  assign ev_start      = (st == ST_STOP) && run_en;
  assign ev_word       = (st == ST_FETCH) && rd_ack;
  assign ev_unowned    = ev_word && (widx == 2'd0) && !rd_data[31];
  assign ev_close      = (st == ST_CLOSE) && wr_ack;
  assign ev_stop_close = ev_close && !run_en;
  assign ev_stop_susp  = (st == ST_SUSP) && !run_en;

  txd_desc_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(ev_word), .idx(widx), .word(rd_data),
    .ctrl(ctrl), .buf1_ptr(job_buf1_addr), .buf2_ptr(job_buf2_addr)
  );

  txd_addr_unit #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_base(ev_start), .advance(ev_close),
    .base(ring_base), .eor(ctrl.eor), .chain(ctrl.chain),
    .chain_ptr(job_buf2_addr), .cur(cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_STOP;
      widx        <= '0;
      err_q       <= 1'b0;
      coll_q      <= '0;
      irq_done    <= 1'b0;
      irq_unavail <= 1'b0;
      irq_stopped <= 1'b0;
    end else begin
      irq_done    <= 1'b0;
      irq_unavail <= 1'b0;
      irq_stopped <= 1'b0;
      unique case (st)
        ST_STOP: if (run_en) begin
          st   <= ST_FETCH;
          widx <= '0;
        end
        ST_FETCH: if (rd_ack) begin
          if (ev_unowned) begin
            st          <= ST_SUSP;
            irq_unavail <= 1'b1;
          end else begin
            widx <= widx + 2'd1;
            if (widx == 2'd3) st <= ST_WAIT;
          end
        end
        ST_WAIT: if (job_ready) st <= ST_READ;
        ST_READ: if (job_done) begin
          st     <= ST_CLOSE;
          err_q  <= job_err;
          coll_q <= job_coll;
        end
        ST_CLOSE: if (wr_ack) begin
          irq_done <= ctrl.last && ctrl.ioc;
          widx     <= '0;
          if (run_en) st <= ST_FETCH;
          else begin
            st          <= ST_STOP;
            irq_stopped <= 1'b1;
          end
        end
        ST_SUSP: begin
          if (!run_en) begin
            st          <= ST_STOP;
            irq_stopped <= 1'b1;
          end else if (poll_req) begin
            st   <= ST_FETCH;
            widx <= '0;
          end
        end
        default: st <= ST_STOP;
      endcase
    end
  end

  assign rd_req       = (st == ST_FETCH);
  assign rd_addr      = cur + AW'({widx, 2'b00});
  assign wr_req       = (st == ST_CLOSE);
  assign wr_addr      = cur;
  assign wr_data      = pack_status(err_q, coll_q);
  assign job_valid    = (st == ST_WAIT);
  assign job_buf1_len = ctrl.len1;
  assign job_buf2_len = eff_len2(ctrl);
  assign job_first    = ctrl.first;
  assign job_last     = ctrl.last;
  assign proc_state   = st;
endmodule

// File: rtl/txd_ring_seq_chk.sv
module txd_ring_seq_chk #(
  parameter int AW = 32,
  parameter int LW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    state,
  input logic          rd_req,
  input logic [3:0]    rd_addr_lo,
  input logic          rd_ack,
  input logic          rd_own,
  input logic          wr_req,
  input logic          wr_own,
  input logic          wr_ack,
  input logic          job_valid,
  input logic          job_ready,
  input logic [AW-1:0] job_buf1_addr,
  input logic [LW-1:0] job_buf1_len,
  input logic          irq_done,
  input logic          irq_unavail,
  input logic          irq_stopped
);
  a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state != 3'b100 && state != 3'b101);

  a_r2_read_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr_lo[1:0] == 2'b00);

  a_r3_unowned_suspends: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'b001 && rd_ack && rd_addr_lo == 4'd0 && !rd_own)
      |=> (state == 3'b110 && irq_unavail));

  a_r3_unavail_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_unavail |=> !irq_unavail);

  a_r5_job_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && !job_ready) |=>
      (job_valid && $stable(job_buf1_addr) && $stable(job_buf1_len)));

  a_r6_wb_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !wr_own);

  a_r8_done_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> ($past(state) == 3'b111 && $past(wr_ack)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  a_r9_stopped_state: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stopped |-> state == 3'b000);
endmodule

bind txd_ring_seq txd_ring_seq_chk #(.AW(AW), .LW(txd_pkg::LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(proc_state), .rd_req(rd_req),
  .rd_addr_lo(rd_addr[3:0]), .rd_ack(rd_ack), .rd_own(rd_data[31]),
  .wr_req(wr_req), .wr_own(wr_data[31]), .wr_ack(wr_ack),
  .job_valid(job_valid), .job_ready(job_ready),
  .job_buf1_addr(job_buf1_addr), .job_buf1_len(job_buf1_len),
  .irq_done(irq_done), .irq_unavail(irq_unavail), .irq_stopped(irq_stopped)
);

// File: tb/tb_txd_ring_seq.sv
module tb_txd_ring_seq;
  logic clk = 0;
  always #2 clk = ~clk;

  logic        rst_n = 0, run_en = 0, poll_req = 0;
  logic [31:0] ring_base = 32'h43;
  logic        rd_req, rd_ack = 0, wr_req, wr_ack = 0;
  logic [31:0] rd_addr, rd_data = 0, wr_addr, wr_data;
  logic        job_valid, job_ready = 0, job_done = 0, job_err = 0;
  logic [3:0]  job_coll = 0;
  logic [31:0] job_buf1_addr, job_buf2_addr;
  logic [10:0] job_buf1_len, job_buf2_len;
  logic        job_first, job_last;
  logic [2:0]  proc_state;
  logic        irq_done, irq_unavail, irq_stopped;

  txd_ring_seq dut (.*);

  int nt = 0, nf = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nt++;
    if (!ok) begin
      nf++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] b1a; logic [10:0] b1l; logic [31:0] b2a; logic [10:0] b2l;
    logic first; logic last;
  } job_t;
  typedef struct packed { logic [31:0] a; logic [31:0] d; logic done; } wb_t;

  job_t        exp_job[$];
  wb_t         exp_wb[$];
  logic [31:0] exp_fetch[$];

  logic [31:0] mem [0:127];
  int n_rd = 0, n_done = 0, n_unav = 0, n_stop = 0, n_acc = 0, jk = 0;
  int wdelay = 0, busy = 0;
  bit last_done_exp = 0;

  function automatic logic [31:0] ctl(bit ioc, bit lst, bit fst, bit eor,
      bit chn, int l2, int l1);
    return (32'(ioc) << 31) | (32'(lst) << 30) | (32'(fst) << 29) |
           (32'(eor) << 25) | (32'(chn) << 24) | ((32'(l2) & 32'h7ff) << 11) |
           (32'(l1) & 32'h7ff);
  endfunction

  // driver: program a descriptor and push what it should produce as job k
  task automatic put_desc(input logic [31:0] a, input logic [31:0] w1,
      input logic [31:0] w2, input logic [31:0] w3, input int k);
    job_t j; wb_t w; bit err; int coll;
    mem[a[8:2]] = 32'h8000_0000; mem[a[8:2]+1] = w1;
    mem[a[8:2]+2] = w2; mem[a[8:2]+3] = w3;
    j.b1a = w2; j.b2a = w3; j.b1l = w1[10:0];
    j.b2l = w1[24] ? 11'd0 : w1[21:11];
    j.first = w1[29]; j.last = w1[30];
    exp_job.push_back(j);
    err = k[0]; coll = (k + 3) % 16;
    w.a = a; w.d = (err ? 32'h8000 : 32'h0) + 32'(coll * 8);
    w.done = w1[30] & w1[31];
    exp_wb.push_back(w);
  endtask

  // memory model + fetch/write monitor
  always @(negedge clk) begin
    if (rd_ack) rd_ack <= 0;
    else if (rd_req) begin
      chk(proc_state == 3'b001, "R2", "state while reading", 32'(proc_state), 32'h1);
      if (rd_addr[3:0] == 4'd0) begin
        logic [31:0] e;
        e = exp_fetch.size() ? exp_fetch.pop_front() : 32'hdead;
        chk(rd_addr == e, "R7", "descriptor address", rd_addr, e);
      end
      rd_data <= mem[rd_addr[8:2]];
      rd_ack  <= 1;
      n_rd++;
    end
    if (wr_ack) begin
      wr_ack <= 0;
      chk(irq_done == last_done_exp, "R8", "completion pulse", 32'(irq_done), 32'(last_done_exp));
    end else if (wr_req) begin
      wb_t w;
      chk(proc_state == 3'b111, "R6", "state while closing", 32'(proc_state), 32'h7);
      w = exp_wb.size() ? exp_wb.pop_front() : '0;
      chk(wr_addr == w.a, "R6", "write-back address", wr_addr, w.a);
      chk(wr_data == w.d, "R6", "write-back word", wr_data, w.d);
      last_done_exp = w.done;
      mem[wr_addr[8:2]] = wr_data;
      wr_ack <= 1;
    end
  end

  // downstream frame-fetch model (scoreboard monitor for jobs)
  always @(negedge clk) begin
    if (job_done) job_done <= 0;
    else if (job_ready) begin job_ready <= 0; busy = 3; end
    else if (busy > 0) begin
      busy--;
      if (busy == 0) begin
        chk(proc_state == 3'b011, "R5", "state while reading data", 32'(proc_state), 32'h3);
        job_done <= 1; job_err <= jk[0]; job_coll <= 4'((jk + 3) % 16); jk++;
      end
    end else if (job_valid) begin
      if (wdelay < 2) begin
        chk(proc_state == 3'b010, "R5", "state while waiting", 32'(proc_state), 32'h2);
        wdelay++;
      end else begin
        job_t e;
        wdelay = 0;
        e = exp_job.size() ? exp_job.pop_front() : '0;
        chk(job_buf1_addr == e.b1a, "R4", "buf1 addr", job_buf1_addr, e.b1a);
        chk(job_buf2_addr == e.b2a, "R4", "buf2 addr", job_buf2_addr, e.b2a);
        chk(job_buf1_len == e.b1l, "R4", "buf1 len", 32'(job_buf1_len), 32'(e.b1l));
        chk(job_buf2_len == e.b2l, "R4", "buf2 len", 32'(job_buf2_len), 32'(e.b2l));
        chk({job_first, job_last} == {e.first, e.last}, "R4", "segment flags",
            32'({job_first, job_last}), 32'({e.first, e.last}));
        job_ready <= 1;
        n_acc++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && irq_done) n_done++;
    if (rst_n && irq_unavail) n_unav++;
    if (rst_n && irq_stopped) n_stop++;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nt++; nf++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(proc_state == 3'b000, "R1", "reset state", 32'(proc_state), 0);
    chk({rd_req, wr_req, job_valid} == 3'b0, "R1", "requests idle",
        32'({rd_req, wr_req, job_valid}), 0);
    chk({irq_done, irq_unavail, irq_stopped} == 3'b0, "R1", "pulses idle",
        32'({irq_done, irq_unavail, irq_stopped}), 0);

    // sequential -> chained -> end of ring (with chain also set)
    put_desc(32'h40, ctl(1, 1, 1, 0, 0, 20, 100), 32'h1000, 32'h2000, 0);
    put_desc(32'h50, ctl(0, 1, 0, 0, 1, 7, 60),   32'h1100, 32'h83,   1);
    put_desc(32'h80, ctl(1, 1, 0, 1, 1, 5, 33),   32'h1200, 32'h100,  2);
    exp_fetch.push_back(32'h40);  // R2 base with low bits dropped
    exp_fetch.push_back(32'h50);  // R7 plus 16
    exp_fetch.push_back(32'h80);  // R7 chain pointer, low bits cleared
    exp_fetch.push_back(32'h40);  // R7 end of ring wins over chain
    run_en = 1;
    while (n_unav < 1) @(negedge clk);
    chk(proc_state == 3'b110, "R3", "suspended state", 32'(proc_state), 32'h6);
    repeat (6) @(negedge clk);
    chk(n_rd == 13, "R3", "no reads after unowned word", 32'(n_rd), 13);
    chk(proc_state == 3'b110, "R3", "stays suspended", 32'(proc_state), 32'h6);

    // hand the first descriptor back and poll
    mem[32'h40 >> 2] = 32'h8000_0000;
    begin
      job_t j; wb_t w; logic [31:0] w1;
      w1 = mem[(32'h40 >> 2) + 1];
      j.b1a = 32'h1000; j.b2a = 32'h2000; j.b1l = 11'd100; j.b2l = 11'd20;
      j.first = 1; j.last = 1;
      exp_job.push_back(j);
      w.a = 32'h40; w.d = 32'h8000 + 32'(6 * 8); w.done = w1[30] & w1[31];
      exp_wb.push_back(w);
    end
    exp_fetch.push_back(32'h40);
    poll_req = 1; @(negedge clk); poll_req = 0;
    while (n_acc < 4) @(negedge clk);
    run_en = 0;
    while (n_stop < 1) @(negedge clk);
    chk(proc_state == 3'b000, "R9", "stopped after close", 32'(proc_state), 0);
    repeat (6) @(negedge clk);
    chk(n_rd == 17, "R9", "no fetch after stop", 32'(n_rd), 17);
    chk(n_done == 3, "R8", "completion pulse count", 32'(n_done), 3);

    // restart: base again, now software-owned, then stop from suspend
    exp_fetch.push_back(32'h40);
    run_en = 1;
    while (n_unav < 2) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_rd == 18, "R3", "single word read when unowned", 32'(n_rd), 18);
    run_en = 0;
    while (n_stop < 2) @(negedge clk);
    chk(proc_state == 3'b000, "R9", "stopped from suspend", 32'(proc_state), 0);
    chk(exp_fetch.size() == 0 && exp_job.size() == 0 && exp_wb.size() == 0,
        "R7", "all expectations consumed",
        32'(exp_fetch.size() + exp_job.size() + exp_wb.size()), 0);
    chk(n_unav == 2, "R3", "unavailable pulse count", 32'(n_unav), 2);
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule